// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a logical address into a final page descriptor by reading a three-level tree of 32-bit descriptors from memory. A request carries the upper logical address bits, a supervisor flag, a write flag and a page-size select. The block picks the supervisor or the user tree root and follows root, pointer and page descriptors through a single 32-bit memory port. A page descriptor may redirect once to a descriptor somewhere else in memory. The block returns the final descriptor with a one-cycle done pulse and a status vector.

While it walks, the block keeps the tree's bookkeeping bits current. It sets the used bit in root and pointer descriptors, and the used and modified bits in the page descriptor, and writes each changed descriptor back in place. Write protection found at the upper levels is folded into the returned descriptor. A memory bus error at any point ends the walk at once with a zero descriptor.

Descriptor bits used throughout: bit 0 resident (page level), bit 1 valid (root and pointer levels), bits[1:0] = 2 indirect (page level), bit 2 write-protect, bit 3 used, bit 4 modified, bit 7 supervisor-only. Status bits: [0] root invalid, [1] pointer invalid, [2] page fault, [3] illegal indirect, [4] walk bus error, [5] supervisor violation.

Top module: `pgtbl_walker`

## Requirements
- R1: The first access reads address {root[31:9], va[31:25], 2'b00}, where root is super_root when req_super is 1 and user_root otherwise.
- R2: The pointer descriptor is read at {root_desc[31:9], va[24:18], 2'b00}.
- R3: The page descriptor is read at {ptr_desc[31:8], va[17:12], 2'b00} when page_8k is 0 and at {ptr_desc[31:7], va[17:13], 2'b00} when page_8k is 1.
- R4: A root or pointer descriptor with bit 1 clear ends the walk with result 0 and status bit 0 (root) or bit 1 (pointer), with no further access.
- R5: A page descriptor with bits[1:0] = 2 makes the block read the descriptor at {desc[31:2], 2'b00}; if that one also has bits[1:0] = 2 the walk ends with status bit 3 and that second descriptor as result.
- R6: A final page descriptor with bit 0 clear (and not double indirect) ends the walk with status bit 2, the descriptor returned unchanged and no write-back.
- R7: Bit 2 of the root or pointer descriptor is ORed into bit 2 of the returned page descriptor.
- R8: A root or pointer descriptor read with bit 3 clear is written back to the same address with bit 3 set before the walk goes on.
- R9: For a write to a page whose merged bit 2 is clear, bits 3 and 4 are set and the descriptor written back unless both were already set; otherwise only a clear bit 3 is set and written back. The returned descriptor equals the written value.
- R10: An access completed with mem_err ends the walk immediately with result 0 and status exactly bit 4; a failed write is not retried.
- R11: A resident page with bit 7 set, walked with req_super 0, returns status bit 5 after the same update and write-back as R9.
- R12: done is a single-cycle pulse per accepted request, and start is ignored while busy is 1.
- R13: mem_req, mem_we, mem_addr and mem_wdata stay stable from the request until the cycle mem_ready is 1, and each access completes in that cycle.
- R14: After reset the block is idle: busy, done, mem_req low and status zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request a walk (taken when idle) |
| req_addr_hi | input | 20 | Logical address bits 31:12 |
| req_super | input | 1 | Supervisor access |
| req_write | input | 1 | Write access |
| page_8k | input | 1 | 1 selects 8 KB pages, 0 selects 4 KB |
| user_root | input | 23 | User tree root, address bits 31:9 |
| super_root | input | 23 | Supervisor tree root, address bits 31:9 |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| result_desc | output | 32 | Final descriptor (held until next walk ends) |
| status | output | 6 | Fault flags, held with result_desc |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write-back |
| mem_addr | output | 32 | Byte address of the descriptor |
| mem_wdata | output | 32 | Write-back data |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access completes this cycle |
| mem_err | input | 1 | Access failed, valid with mem_ready |

## Verification
A wrong latched access type or tree level shows up as a wrong address on the very next memory request, so the bench compares every request address, direction and write value in order against a walk computed from the descriptor rules. A lost write-protect or used bit shows only at the end, in the returned descriptor or the write-back data, a few accesses later. A stuck state shows as a missing or repeated done pulse or an extra access. Sweeps randomise descriptors, tree shape, page size, access type, memory latency and the access on which a bus error lands.

// File: rtl/pgtbl_pkg.sv
// Shared constants and types for the page table walker.
// Assumes 32-bit logical and physical addresses and 4-byte descriptors.
package pgtbl_pkg;
    localparam int VA_W       = 32;
    localparam int DESC_W     = 32;
    localparam int ROOT_LSB   = 25;            // root index = va[31:25]
    localparam int PTR_LSB    = 18;            // pointer index = va[24:18]
    localparam int PG4_LSB    = 12;            // 4 KB page index = va[17:12]
    localparam int PG8_LSB    = 13;            // 8 KB page index = va[17:13]
    localparam int TBL_ALIGN  = 9;             // root and pointer tables: 512 bytes
    localparam int PT4_ALIGN  = 8;             // 4 KB page tables: 256 bytes
    localparam int PT8_ALIGN  = 7;             // 8 KB page tables: 128 bytes
    localparam int VPN_LSB    = PG4_LSB;       // lowest logical bit the walk needs

    // descriptor bit positions
    localparam int D_RES  = 0;
    localparam int D_VLD  = 1;
    localparam int D_WP   = 2;
    localparam int D_USED = 3;
    localparam int D_MOD  = 4;
    localparam int D_SUP  = 7;
    localparam logic [1:0] TYPE_INDIRECT = 2'b10;

    // status bit positions
    localparam int STAT_W   = 6;
    localparam int ST_ROOT  = 0;
    localparam int ST_PTR   = 1;
    localparam int ST_PF    = 2;
    localparam int ST_IND   = 3;
    localparam int ST_BUS   = 4;
    localparam int ST_SUPV  = 5;

    typedef enum logic [2:0] {
        S_IDLE, S_RD_ROOT, S_WB_ROOT, S_RD_PTR,
        S_WB_PTR, S_RD_PAGE, S_RD_IND, S_WB_PAGE
    } walk_st_e;

    typedef struct packed {
        logic [DESC_W-1:0] root;
        logic [DESC_W-1:0] ptr;
        logic [DESC_W-1:0] page;
        logic [DESC_W-1:0] ind;
    } walk_addr_t;
endpackage

// File: rtl/pgtbl_addr_gen.sv
// Descriptor address generator: forms the byte address of the next
// descriptor for every level from the logical address and a table base.
// Assumes bases are aligned as the package states; low base bits are dropped.
module pgtbl_addr_gen
    import pgtbl_pkg::*;
(
    input  logic [VA_W-1:VPN_LSB]       va_hi,
    input  logic [VA_W-1:TBL_ALIGN]     root_base,
    input  logic [DESC_W-1:0]           tbl_desc,
    input  logic                        big_page,
    output walk_addr_t                  addrs
);
    localparam int RIDX_W = VA_W - ROOT_LSB;
    localparam int PIDX_W = ROOT_LSB - PTR_LSB;

    logic [DESC_W-1:0] page4;
    logic [DESC_W-1:0] page8;

    // Concatenate base and index for each level; pick the page-size variant.
    always_comb begin
        addrs.root = {root_base, va_hi[VA_W-1 -: RIDX_W], 2'b00};
        addrs.ptr  = {tbl_desc[DESC_W-1:TBL_ALIGN], va_hi[ROOT_LSB-1 -: PIDX_W], 2'b00};
        page4      = {tbl_desc[DESC_W-1:PT4_ALIGN], va_hi[PTR_LSB-1:PG4_LSB], 2'b00};
        page8      = {tbl_desc[DESC_W-1:PT8_ALIGN], va_hi[PTR_LSB-1:PG8_LSB], 2'b00};
        addrs.page = big_page ? page8 : page4;
        addrs.ind  = {tbl_desc[DESC_W-1:2], 2'b00};
    end
endmodule

// File: rtl/pgtbl_page_eval.sv
// Page descriptor evaluator: merges upper-level write protection, decides
// which bookkeeping bits must change and flags the final fault conditions.
// Assumes it is only consulted for the last descriptor of a walk.
module pgtbl_page_eval
    import pgtbl_pkg::*;
(
    input  logic [DESC_W-1:0] desc_in,
    input  logic              wp_upper,
    input  logic              is_write,
    input  logic              is_super,
    input  logic              via_ind,
    output logic              bad_ind,
    output logic              non_res,
    output logic              need_wb,
    output logic              sup_viol,
    output logic [DESC_W-1:0] desc_out
);
    logic [DESC_W-1:0] merged;
    logic [DESC_W-1:0] um_mask;
    logic [DESC_W-1:0] u_mask;

    // Compute merged descriptor, the updated value and the fault flags.
    always_comb begin
        um_mask  = '0;
        um_mask[D_USED] = 1'b1;
        um_mask[D_MOD]  = 1'b1;
        u_mask   = '0;
        u_mask[D_USED]  = 1'b1;
        merged   = desc_in;
        merged[D_WP] = desc_in[D_WP] | wp_upper;
        bad_ind  = via_ind && (desc_in[1:0] == TYPE_INDIRECT);
        non_res  = !desc_in[D_RES];
        if (is_write && !merged[D_WP]) begin
            desc_out = merged | um_mask;
            need_wb  = !(merged[D_USED] && merged[D_MOD]);
        end else begin
            desc_out = merged | u_mask;
            need_wb  = !merged[D_USED];
        end
        sup_viol = desc_in[D_RES] && !is_super && desc_in[D_SUP];
    end
endmodule

// File: rtl/pgtbl_walker.sv
// Three-level page table walker: sequences root, pointer, page and optional
// indirect descriptor reads over one memory port, writes back descriptors
// whose bookkeeping bits change, and reports the final descriptor and faults.
// Assumes the memory holds mem_rdata/mem_err valid only with mem_ready.
module pgtbl_walker
    import pgtbl_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [VA_W-1:VPN_LSB]   req_addr_hi,
    input  logic                    req_super,
    input  logic                    req_write,
    input  logic                    page_8k,
    input  logic [VA_W-1:TBL_ALIGN] user_root,
    input  logic [VA_W-1:TBL_ALIGN] super_root,
    output logic                    busy,
    output logic                    done,
    output logic [DESC_W-1:0]       result_desc,
    output logic [STAT_W-1:0]       status,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [DESC_W-1:0]       mem_addr,
    output logic [DESC_W-1:0]       mem_wdata,
    input  logic [DESC_W-1:0]       mem_rdata,
    input  logic                    mem_ready,
    input  logic                    mem_err
);
    walk_st_e                state, state_n;
    logic [VA_W-1:VPN_LSB]   va_q, va_cur;
    logic                    sup_q, wr_q, big_q, big_cur;
    logic                    wp_q, wp_n, sv_q, sv_n;
    logic [DESC_W-1:0]       maddr_q, maddr_n, wdata_q, wdata_n, desc_q, desc_n;
    logic [DESC_W-1:0]       tbl_src, res_q, fin_desc;
    logic [STAT_W-1:0]       stat_q, fin_stat;
    logic                    done_q, fin, hs, in_wb;
    walk_addr_t              ag;
    logic                    ev_bad_ind, ev_non_res, ev_need, ev_sv;
    logic [DESC_W-1:0]       ev_desc;
    logic [DESC_W-1:0]       used_mask;

    assign used_mask = DESC_W'(1) << D_USED;
    assign in_wb   = (state == S_WB_ROOT) || (state == S_WB_PTR) || (state == S_WB_PAGE);
    assign mem_req = (state != S_IDLE);
    assign mem_we  = in_wb;
    assign mem_addr  = maddr_q;
    assign mem_wdata = wdata_q;
    assign busy    = mem_req;
    assign hs      = mem_req && mem_ready;
    assign done    = done_q;
    assign result_desc = res_q;
    assign status  = stat_q;

    // Address inputs come from the request while idle, else from latched state.
    assign va_cur  = (state == S_IDLE) ? req_addr_hi : va_q;
    assign big_cur = (state == S_IDLE) ? page_8k : big_q;
    assign tbl_src = in_wb ? desc_q : mem_rdata;

    pgtbl_addr_gen u_agen (
        .va_hi     (va_cur),
        .root_base (req_super ? super_root : user_root),
        .tbl_desc  (tbl_src),
        .big_page  (big_cur),
        .addrs     (ag)
    );

    pgtbl_page_eval u_eval (
        .desc_in  (mem_rdata),
        .wp_upper (wp_q),
        .is_write (wr_q),
        .is_super (sup_q),
        .via_ind  (state == S_RD_IND),
        .bad_ind  (ev_bad_ind),
        .non_res  (ev_non_res),
        .need_wb  (ev_need),
        .sup_viol (ev_sv),
        .desc_out (ev_desc)
    );

    // Next-state, next-access and end-of-walk decisions.
    always_comb begin
        state_n  = state;
        maddr_n  = maddr_q;
        wdata_n  = wdata_q;
        desc_n   = desc_q;
        wp_n     = wp_q;
        sv_n     = sv_q;
        fin      = 1'b0;
        fin_desc = '0;
        fin_stat = '0;
        case (state)
            S_IDLE: if (start) begin
                state_n = S_RD_ROOT;
                maddr_n = ag.root;
                wp_n    = 1'b0;
                sv_n    = 1'b0;
            end
            S_RD_ROOT, S_RD_PTR: if (hs) begin
                if (!mem_rdata[D_VLD]) begin
                    fin = 1'b1;
                    fin_stat[(state == S_RD_ROOT) ? ST_ROOT : ST_PTR] = 1'b1;
                end else begin
                    wp_n   = wp_q | mem_rdata[D_WP];
                    desc_n = mem_rdata;
                    if (!mem_rdata[D_USED]) begin
                        state_n = (state == S_RD_ROOT) ? S_WB_ROOT : S_WB_PTR;
                        wdata_n = mem_rdata | used_mask;
                    end else begin
                        state_n = (state == S_RD_ROOT) ? S_RD_PTR : S_RD_PAGE;
                        maddr_n = (state == S_RD_ROOT) ? ag.ptr : ag.page;
                    end
                end
            end
            S_WB_ROOT, S_WB_PTR: if (hs) begin
                state_n = (state == S_WB_ROOT) ? S_RD_PTR : S_RD_PAGE;
                maddr_n = (state == S_WB_ROOT) ? ag.ptr : ag.page;
            end
            S_RD_PAGE, S_RD_IND: if (hs) begin
                if (state == S_RD_PAGE && mem_rdata[1:0] == TYPE_INDIRECT) begin
                    state_n = S_RD_IND;
                    maddr_n = ag.ind;
                end else if (ev_bad_ind) begin
                    fin = 1'b1;
                    fin_desc = mem_rdata;
                    fin_stat[ST_IND] = 1'b1;
                end else if (ev_non_res) begin
                    fin = 1'b1;
                    fin_desc = mem_rdata;
                    fin_stat[ST_PF] = 1'b1;
                end else if (ev_need) begin
                    state_n = S_WB_PAGE;
                    wdata_n = ev_desc;
                    desc_n  = ev_desc;
                    sv_n    = ev_sv;
                end else begin
                    fin = 1'b1;
                    fin_desc = ev_desc;
                    fin_stat[ST_SUPV] = ev_sv;
                end
            end
            S_WB_PAGE: if (hs) begin
                fin = 1'b1;
                fin_desc = desc_q;
                fin_stat[ST_SUPV] = sv_q;
            end
            default: state_n = S_IDLE;
        endcase
        // A failed access overrides every other outcome.
        if (hs && mem_err) begin
            fin      = 1'b1;
            fin_desc = '0;
            fin_stat = '0;
            fin_stat[ST_BUS] = 1'b1;
        end
        if (fin) state_n = S_IDLE;
    end

    // State registers, request capture and result holding.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            va_q    <= '0;
            sup_q   <= 1'b0;
            wr_q    <= 1'b0;
            big_q   <= 1'b0;
            wp_q    <= 1'b0;
            sv_q    <= 1'b0;
            maddr_q <= '0;
            wdata_q <= '0;
            desc_q  <= '0;
            res_q   <= '0;
            stat_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            state   <= state_n;
            maddr_q <= maddr_n;
            wdata_q <= wdata_n;
            desc_q  <= desc_n;
            wp_q    <= wp_n;
            sv_q    <= sv_n;
            done_q  <= fin;
            if (state == S_IDLE && start) begin
                va_q  <= req_addr_hi;
                sup_q <= req_super;
                wr_q  <= req_write;
                big_q <= page_8k;
            end
            if (fin) begin
                res_q  <= fin_desc;
                stat_q <= fin_stat;
            end
        end
    end
endmodule

// File: rtl/pgtbl_walker_chk.sv
// Checker for the page table walker: port-level protocol and outcome rules.
// Assumes the clock and synchronous active-low reset of the walker.
module pgtbl_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        done,
    input logic [31:0] result_desc,
    input logic [5:0]  status,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic        mem_ready
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R13
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R12
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R12
    AST_ONE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $onehot0(status)); // R10
    AST_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status[4]) |-> (result_desc == 32'h0)); // R10
    AST_INVALID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (status[0] || status[1])) |-> (result_desc == 32'h0)); // R4
    AST_WB_USED: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> mem_wdata[3]); // R8
endmodule

bind pgtbl_walker pgtbl_walker_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .done        (done),
    .result_desc (result_desc),
    .status      (status),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_ready   (mem_ready)
);

// File: tb/pgtbl_walker_tb.sv
// Bench for the page table walker: randomised descriptor trees, a reference
// walk computed from the requirements, and a latency/error memory model.
module pgtbl_walker_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N_WALKS    = 3000;
    localparam logic [31:0] UROOT = 32'h0000_1000;
    localparam logic [31:0] SROOT = 32'h0000_2000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:12] req_addr_hi = '0;
    logic        req_super = 1'b0, req_write = 1'b0, page_8k = 1'b0;
    logic        busy, done, mem_req, mem_we;
    logic [31:0] result_desc, mem_addr, mem_wdata;
    logic [5:0]  status;
    logic [31:0] mem_rdata = '0;
    logic        mem_ready = 1'b0, mem_err = 1'b0;

    int tests = 0, fails = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pgtbl_walker u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .req_addr_hi(req_addr_hi),
        .req_super(req_super), .req_write(req_write), .page_8k(page_8k),
        .user_root(UROOT[31:9]), .super_root(SROOT[31:9]),
        .busy(busy), .done(done), .result_desc(result_desc), .status(status),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready), .mem_err(mem_err)
    );

    // ---------------- memory model ----------------
    logic [31:0] mem [logic [31:0]];
    logic [31:0] txn_addr [int];
    logic [31:0] txn_wd [int];
    bit          txn_we [int];
    int  txn_idx = 0;
    int  err_at = -1;
    int  lat = 0;
    int  wait_cnt = 0;
    bit  pend = 0, pend_we = 0, pend_err = 0;
    logic [31:0] pend_addr = '0, pend_data = '0;

    function automatic logic [31:0] rdm(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    // Commit the last accepted access, then present the current one.
    always @(negedge clk) begin
        if (pend) begin
            if (pend_we && !pend_err) mem[pend_addr] = pend_data;
            pend = 0;
        end
        if (rst_n && mem_req) begin
            if (wait_cnt == 0) begin
                mem_ready = 1'b1;
                mem_err   = (txn_idx == err_at);
                mem_rdata = mem_err ? 32'hFFFF_FFFF : rdm(mem_addr);
                txn_addr[txn_idx] = mem_addr;
                txn_we[txn_idx]   = mem_we;
                txn_wd[txn_idx]   = mem_wdata;
                pend = 1; pend_we = mem_we; pend_err = mem_err;
                pend_addr = mem_addr; pend_data = mem_wdata;
                txn_idx++;
                wait_cnt = lat;
            end else begin
                mem_ready = 1'b0;
                mem_err   = 1'b0;
                wait_cnt--;
            end
        end else begin
            mem_ready = 1'b0;
            mem_err   = 1'b0;
            wait_cnt  = lat;
        end
    end

    // ---------------- reference walk ----------------
    logic [31:0] exp_addr [0:7];
    logic [31:0] exp_wd [0:7];
    bit          exp_we [0:7];
    string       exp_tag [0:7];
    int          exp_n;
    logic [31:0] exp_res;
    logic [5:0]  exp_st;

    // Record one expected access; returns 1 when it is the failing one.
    function automatic bit acc(input logic [31:0] a, input bit we, input logic [31:0] d,
                               input string tg, input int errrel);
        exp_addr[exp_n] = a; exp_we[exp_n] = we; exp_wd[exp_n] = d; exp_tag[exp_n] = tg;
        exp_n++;
        return (exp_n - 1) == errrel;
    endfunction

    task automatic model(input logic [31:0] va, input bit sup, wr, big,
                         input int errrel, output string tg);
        logic [31:0] ra, rd, pa, pd, ga, gd;
        bit wp, need;
        exp_n = 0; exp_res = 0; exp_st = 0; tg = "R9";
        ra = (sup ? SROOT : UROOT) + ((va >> 23) & 32'h1FC);
        if (acc(ra, 0, 0, "R1", errrel)) begin exp_st = 6'h10; tg = "R10"; return; end
        rd = rdm(ra);
        if (!rd[1]) begin exp_st = 6'h01; tg = "R4"; return; end
        wp = rd[2];
        if (!rd[3]) if (acc(ra, 1, rd | 32'h8, "R8", errrel)) begin exp_st = 6'h10; tg = "R10"; return; end
        pa = (rd & 32'hFFFF_FE00) + ((va >> 16) & 32'h1FC);
        if (acc(pa, 0, 0, "R2", errrel)) begin exp_st = 6'h10; tg = "R10"; return; end
        pd = rdm(pa);
        if (!pd[1]) begin exp_st = 6'h02; tg = "R4"; return; end
        wp = wp | pd[2];
        if (!pd[3]) if (acc(pa, 1, pd | 32'h8, "R8", errrel)) begin exp_st = 6'h10; tg = "R10"; return; end
        ga = big ? (pd & 32'hFFFF_FF80) + ((va >> 11) & 32'h7C)
                 : (pd & 32'hFFFF_FF00) + ((va >> 10) & 32'hFC);
        if (acc(ga, 0, 0, "R3", errrel)) begin exp_st = 6'h10; tg = "R10"; return; end
        gd = rdm(ga);
        if (gd[1:0] == 2'd2) begin
            ga = gd & 32'hFFFF_FFFC;
            tg = "R5";
            if (acc(ga, 0, 0, "R5", errrel)) begin exp_st = 6'h10; tg = "R10"; return; end
            gd = rdm(ga);
            if (gd[1:0] == 2'd2) begin exp_st = 6'h08; exp_res = gd; return; end
        end
        if (!gd[0]) begin exp_st = 6'h04; exp_res = gd; tg = "R6"; return; end
        if (wp) begin gd = gd | 32'h4; tg = "R7"; end
        need = 0;
        if (wr && !gd[2]) begin
            if ((gd & 32'h18) != 32'h18) begin gd = gd | 32'h18; need = 1; end
        end else if (!gd[3]) begin
            gd = gd | 32'h8; need = 1;
        end
        if (need) if (acc(ga, 1, gd, "R9", errrel)) begin exp_st = 6'h10; tg = "R10"; return; end
        if (!sup && gd[7]) begin exp_st = 6'h20; tg = "R11"; end
        exp_res = gd;
    endtask

    // ---------------- checking ----------------
    task automatic chk(input bit ok, input string tg, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tg, what, act, expv);
        end
    endtask

    task automatic run_walk(input logic [31:0] va, input bit sup, wr, big,
                            input int errrel, input int lt, input bit poke);
        string tg;
        int base, cyc, ntx;
        logic [31:0] got_res;
        logic [5:0]  got_st;
        model(va, sup, wr, big, errrel, tg);
        base   = txn_idx;
        err_at = (errrel < 0) ? -1 : base + errrel;
        lat    = lt;
        @(negedge clk);
        start = 1; req_addr_hi = va[31:12]; req_super = sup; req_write = wr; page_8k = big;
        @(negedge clk);
        start = 0;
        if (poke) begin
            // R12: a second request while busy must not start a walk
            req_addr_hi = ~va[31:12]; start = 1;
            @(negedge clk);
            start = 0;
        end
        cyc = 0;
        while (!done && cyc < 100) begin @(negedge clk); cyc++; end
        if (!done) begin
            tests++; fails++;
            $display("FAIL R12 watchdog: actual %h expected %h", 0, 1);
            return;
        end
        got_res = result_desc; got_st = status;
        @(negedge clk);
        chk(!done, "R12", "done width", {31'h0, done}, 32'h0);
        ntx = txn_idx - base;
        chk(got_res == exp_res, tg, "result", got_res, exp_res);
        chk(got_st == exp_st, tg, "status", {26'h0, got_st}, {26'h0, exp_st});
        chk(ntx == exp_n, "R13", "access count", ntx, exp_n);
        for (int k = 0; k < exp_n && k < ntx; k++) begin
            chk(txn_addr[base+k] == exp_addr[k], exp_tag[k], "access address", txn_addr[base+k], exp_addr[k]);
            chk(txn_we[base+k] == exp_we[k], exp_tag[k], "access direction", {31'h0, txn_we[base+k]}, {31'h0, exp_we[k]});
            if (exp_we[k])
                chk(txn_wd[base+k] == exp_wd[k], exp_tag[k], "write-back data", txn_wd[base+k], exp_wd[k]);
        end
        if (poke) begin
            repeat (4) @(negedge clk);
            chk((txn_idx - base) == ntx && !busy, "R12", "no walk from ignored start", txn_idx - base, ntx);
        end
    endtask

    function automatic logic [31:0] xs(input logic [31:0] s);
        logic [31:0] t;
        t = s ^ (s << 13);
        t = t ^ (t >> 17);
        return t ^ (t << 5);
    endfunction

    // Build a random tree around one logical address.
    task automatic build(input logic [31:0] va, input bit sup, input bit big, inout logic [31:0] s,
                         input bit force_ok);
        logic [31:0] ra, ro, pa, ga, ia, r, pt;
        int ptype, itype;
        mem.delete();
        s = xs(s); r = s;
        ra = (sup ? SROOT : UROOT) + {23'h0, va[31:25], 2'b00};
        ro = (sup ? UROOT : SROOT) + {23'h0, va[31:25], 2'b00};
        mem[ro] = 32'h0000_7000 | 32'hA;
        mem[ra] = 32'h0000_3000 | {28'h0, r[3], (r[2:0] == 0 && !force_ok) ? 1'b0 : 1'b1, 1'b1, r[4]} & 32'hFFFF_FFFF;
        mem[ra][2] = (r[6:5] == 0);
        mem[ra][3] = force_ok ? 1'b0 : r[7];
        pa = 32'h0000_3000 + {23'h0, va[24:18], 2'b00};
        mem[pa] = 32'h0000_4000;
        mem[pa][0] = r[8];
        mem[pa][1] = (r[11:9] != 0) || force_ok;
        mem[pa][2] = (r[13:12] == 0);
        mem[pa][3] = force_ok ? 1'b0 : r[14];
        ga = big ? 32'h0000_4000 + {25'h0, va[17:13], 2'b00} : 32'h0000_4000 + {24'h0, va[17:12], 2'b00};
        s = xs(s); r = s;
        ptype = force_ok ? 3 : int'(r[2:0]);
        itype = int'(r[5:3]);
        ia = 32'h0000_5000 + {24'h0, r[11:6], 2'b00};
        pt = (r & 32'hFFFF_F000) | {24'h0, r[12], 2'b00, r[13] & !force_ok, r[14], r[15] & !force_ok, 2'b00};
        if (ptype == 0) mem[ga] = pt;                         // non-resident
        else if (ptype <= 2) begin
            mem[ga] = ia | 32'h2;                             // indirect
            if (itype == 0)      mem[ia] = pt;
            else if (itype == 1) mem[ia] = 32'h0000_6000 | 32'h2;
            else                 mem[ia] = pt | {31'h0, 1'b1} | {30'h0, r[16], 1'b0};
        end else mem[ga] = pt | 32'h1 | {30'h0, r[16], 1'b0};
    endtask

    // ---------------- stimulus ----------------
    initial begin
        logic [31:0] s, va, r;
        s = 32'h1234_5678;
        repeat (3) @(negedge clk);
        // R14: reset state
        chk(!busy && !done && !mem_req && status == 0, "R14", "reset state",
            {busy, done, mem_req, 23'h0, status}, 32'h0);
        rst_n = 1;
        @(negedge clk);
        chk(!busy && !mem_req, "R14", "idle after reset", {30'h0, busy, mem_req}, 32'h0);
        // R12: directed walk with every level needing write-back and a poked start
        va = 32'hA5C3_7123;
        build(va, 1'b0, 1'b0, s, 1'b1);
        run_walk(va, 1'b0, 1'b1, 1'b0, -1, 1, 1'b1);
        // near-exhaustive sweep over tree shapes, access types and bus errors
        for (int i = 0; i < N_WALKS; i++) begin
            s = xs(s); va = s;
            s = xs(s); r = s;
            build(va, r[0], r[2], s, 1'b0);
            run_walk(va, r[0], r[1], r[2], (r[5:4] == 0) ? int'(r[8:6]) % 6 : -1, int'(r[3]), 1'b0);
        end
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // Global watchdog: a hung run counts as one failed check.
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            tests++; fails++;
            $display("FAIL R12 global watchdog: actual %h expected %h", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule